// File: doc/BRIEF.md
# RGMII Transmit Double-Data-Rate Encoder

This block turns a byte-wide transmit stream (eight data bits, an enable and an error flag) into the narrow transmit pin set of a reduced gigabit MAC-to-PHY link. The pin set has four data lines, one control line and a forwarded clock. Everything runs from a single 125 MHz source clock. For each source cycle the block produces two values for every pin: one for the first half of the cycle and one for the second. An external double-data-rate output cell, which is not part of this block, takes the first-half value on the rising edge and the second-half value on the falling edge. The forwarded clock is carried the same way, so the MAC side always generates it.

A speed select input picks gigabit, 100 Mbit/s or 10 Mbit/s operation. At gigabit the block takes one byte per source cycle and sends its two nibbles on the two half cycles. At the two lower rates the forwarded clock is the source clock divided by 5 or by 50. Each byte then occupies two forwarded-clock periods, one nibble per period. The block raises `byte_take` in every cycle in which it samples the input byte, which sets the pace for the upstream MAC. A new speed is adopted only at a byte boundary where the sampled enable is low, so a frame never changes rate partway through. Carrier sense and collision are not carried by this interface.

Top module: `rgmii_tx_ddr_enc`

## Requirements
- R1: While reset is asserted all pin outputs (data, control and clock, both halves) are 0. `byte_take` is high in the first cycle after reset is released.
- R2: With speed select 2'b10 or 2'b11 (gigabit), `byte_take` is high in every cycle. The data pins carry byte bits [3:0] in the first half of a cycle and bits [7:4] in the second half. The clock is 1 in the first half and 0 in the second half.
- R3: At gigabit the control pin carries the enable in the first half and enable XOR error in the second half, so an idle byte with error set gives 0 then 1.
- R4: With speed select 2'b01 (100 Mbit/s, divide by 5) or 2'b00 (10 Mbit/s, divide by 50), the clock period is N source cycles. The clock is high for the first N half-cycles of each period and low for the remaining N.
- R5: At 10/100 a byte spans two clock periods: bits [3:0] throughout the first period and bits [7:4] throughout the second. The same nibble appears in both halves of every cycle, and successive `byte_take` pulses are exactly 2N cycles apart.
- R6: At 10/100 the control pin carries the enable in both halves and the error input has no effect on it.
- R7: Speed select is adopted only at a rising edge where `byte_take` is high and the enable being sampled is low. The byte sampled at that edge already uses the new rate. Changes while enable is high have no effect.
- R8: A byte sampled at a rising edge with `byte_take` high appears on the pins from the second rising edge after that one. The forwarded clock is delayed by the same amount, so it stays aligned with the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Transmit byte |
| tx_en | input | 1 | Transmit enable for the byte |
| tx_er | input | 1 | Transmit error for the byte |
| speed_sel | input | 2 | 00 = 10 Mbit/s, 01 = 100 Mbit/s, 1x = gigabit |
| byte_take | output | 1 | High in a cycle whose rising edge samples the input byte |
| txd_rise | output | 4 | Data pin value for the first half cycle |
| txd_fall | output | 4 | Data pin value for the second half cycle |
| ctl_rise | output | 1 | Control pin value for the first half cycle |
| ctl_fall | output | 1 | Control pin value for the second half cycle |
| txc_rise | output | 1 | Forwarded clock value for the first half cycle |
| txc_fall | output | 1 | Forwarded clock value for the second half cycle |

## Verification
A wrong slot counter or nibble flag shows up within one forwarded-clock period. It appears as a clock with the wrong duty or period, or as a nibble that changes in the middle of a period, and the per-cycle comparison flags it two cycles after the faulty state. A speed latched at the wrong moment shows in the spacing between `byte_take` pulses and in the clock period of the very next byte. Mixed-up nibbles or control encoding appear on the first byte of a frame.

// File: rtl/rgtx_pkg.sv
package rgtx_pkg;

    typedef enum logic [1:0] {
        SPD_10M    = 2'b00,
        SPD_100M   = 2'b01,
        SPD_1G     = 2'b10,
        SPD_1G_ALT = 2'b11
    } rgtx_speed_e;

    typedef struct packed {
        logic [3:0] d_rise;
        logic [3:0] d_fall;
        logic       c_rise;
        logic       c_fall;
        logic       k_rise;
        logic       k_fall;
    } rgtx_pins_t;

endpackage

// File: rtl/rgtx_rate.sv
module rgtx_rate #(
    parameter int DIV_100 = 5,
    parameter int DIV_10  = 50,
    parameter int CNT_W   = $clog2(DIV_10 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             tx_en,
    input  logic [1:0]       speed_sel,
    output logic [1:0]       spd_q,
    output logic [CNT_W-1:0] div_n
);
    import rgtx_pkg::*;

    typedef struct packed {
        logic [1:0] spd;
    } rate_t;

    rate_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // rate switch only at an idle byte boundary
        if (take && !tx_en) begin
            r_d.spd = speed_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.spd <= SPD_10M;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.spd)
            SPD_10M:  div_n = CNT_W'(DIV_10);
            SPD_100M: div_n = CNT_W'(DIV_100);
            default:  div_n = CNT_W'(1);
        endcase
    end

    assign spd_q = r_q.spd;

endmodule

// File: rtl/rgtx_pace.sv
module rgtx_pace #(
    parameter int DIV_10 = 50,
    parameter int CNT_W  = $clog2(DIV_10 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_gig,
    input  logic [CNT_W-1:0] div_n,
    output logic             take,
    output logic [CNT_W-1:0] cyc_q,
    output logic             nib_q
);
    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic             nib;
    } pace_t;

    pace_t p_d, p_q;
    logic  last_cyc;

    always_comb begin
        last_cyc = (p_q.cyc >= div_n - CNT_W'(1));
        take     = last_cyc && (p_q.nib || is_gig);
        p_d      = p_q;
        if (take) begin
            p_d.cyc = '0;
            p_d.nib = 1'b0;
        end else if (last_cyc) begin
            p_d.cyc = '0;
            p_d.nib = 1'b1;
        end else begin
            p_d.cyc = p_q.cyc + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.cyc <= CNT_W'(DIV_10 - 1);
            p_q.nib <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign cyc_q = p_q.cyc;
    assign nib_q = p_q.nib;

endmodule

// File: rtl/rgtx_lane.sv
module rgtx_lane #(
    parameter int DIV_10 = 50,
    parameter int CNT_W  = $clog2(DIV_10 + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic [7:0]           tx_data,
    input  logic                 tx_en,
    input  logic                 tx_er,
    input  logic                 is_gig,
    input  logic [CNT_W-1:0]     div_n,
    input  logic [CNT_W-1:0]     cyc_q,
    input  logic                 nib_q,
    output rgtx_pkg::rgtx_pins_t pins
);
    import rgtx_pkg::*;

    typedef struct packed {
        logic [7:0] hold;
        logic       en;
        logic       er;
        rgtx_pins_t out;
    } lane_t;

    lane_t        l_d, l_q;
    logic [CNT_W:0] half_r, half_f, lim;
    logic [3:0]   nibble;

    always_comb begin
        l_d    = l_q;
        half_r = {cyc_q, 1'b0};
        half_f = {cyc_q, 1'b1};
        lim    = {1'b0, div_n};
        nibble = nib_q ? l_q.hold[7:4] : l_q.hold[3:0];

        // forwarded clock: high for the first div_n half-cycles
        l_d.out.k_rise = (half_r < lim);
        l_d.out.k_fall = (half_f < lim);

        if (is_gig) begin
            l_d.out.d_rise = l_q.hold[3:0];
            l_d.out.d_fall = l_q.hold[7:4];
            l_d.out.c_rise = l_q.en;
            l_d.out.c_fall = l_q.en ^ l_q.er;
        end else begin
            l_d.out.d_rise = nibble;
            l_d.out.d_fall = nibble;
            l_d.out.c_rise = l_q.en;
            l_d.out.c_fall = l_q.en;
        end

        if (take) begin
            l_d.hold = tx_data;
            l_d.en   = tx_en;
            l_d.er   = tx_er;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign pins = l_q.out;

endmodule

// File: rtl/rgmii_tx_ddr_enc.sv
module rgmii_tx_ddr_enc #(
    parameter int DIV_100 = 5,
    parameter int DIV_10  = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic [1:0] speed_sel,
    output logic       byte_take,
    output logic [3:0] txd_rise,
    output logic [3:0] txd_fall,
    output logic       ctl_rise,
    output logic       ctl_fall,
    output logic       txc_rise,
    output logic       txc_fall
);
    import rgtx_pkg::*;

    localparam int CNT_W = $clog2(DIV_10 + 1);

    logic [1:0]       rate_spd;
    logic [CNT_W-1:0] div_n;
    logic             gig;
    logic             take;
    logic [CNT_W-1:0] cyc;
    logic             nib;
    rgtx_pins_t       pins;

    assign gig = rate_spd[1];

    rgtx_rate #(.DIV_100(DIV_100), .DIV_10(DIV_10), .CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .take(take), .tx_en(tx_en),
        .speed_sel(speed_sel), .spd_q(rate_spd), .div_n(div_n)
    );

    rgtx_pace #(.DIV_10(DIV_10), .CNT_W(CNT_W)) u_pace (
        .clk(clk), .rst_n(rst_n), .is_gig(gig), .div_n(div_n),
        .take(take), .cyc_q(cyc), .nib_q(nib)
    );

    rgtx_lane #(.DIV_10(DIV_10), .CNT_W(CNT_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .take(take), .tx_data(tx_data),
        .tx_en(tx_en), .tx_er(tx_er), .is_gig(gig), .div_n(div_n),
        .cyc_q(cyc), .nib_q(nib), .pins(pins)
    );

    assign byte_take = take;
    assign txd_rise  = pins.d_rise;
    assign txd_fall  = pins.d_fall;
    assign ctl_rise  = pins.c_rise;
    assign ctl_fall  = pins.c_fall;
    assign txc_rise  = pins.k_rise;
    assign txc_fall  = pins.k_fall;

endmodule

// File: rtl/rgtx_chk.sv
module rgtx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       byte_take,
    input logic [1:0] spd,
    input logic [3:0] txd_rise,
    input logic [3:0] txd_fall,
    input logic       ctl_rise,
    input logic       ctl_fall,
    input logic       txc_rise,
    input logic       txc_fall
);
    // R2: gigabit slot drives a full clock pulse each cycle
    a_r2_gig_txc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spd[1]) |-> (txc_rise && !txc_fall));

    // R2: gigabit takes a byte every cycle
    a_r2_take_each: assert property (@(posedge clk) disable iff (!rst_n)
        spd[1] |-> byte_take);

    // R4: clock never goes low then high inside one cycle
    a_r4_txc_order: assert property (@(posedge clk) disable iff (!rst_n)
        txc_fall |-> txc_rise);

    // R5, R6: 10/100 slots repeat the same value in both halves
    a_r5_same_halves: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(spd[1]) |-> (txd_rise == txd_fall && ctl_rise == ctl_fall));

    // R7: rate only moves at an idle byte boundary
    a_r7_speed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (spd != $past(spd)) |-> ($past(byte_take) && !$past(tx_en)));

endmodule

bind rgmii_tx_ddr_enc rgtx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .byte_take(byte_take),
    .spd(rate_spd), .txd_rise(txd_rise), .txd_fall(txd_fall),
    .ctl_rise(ctl_rise), .ctl_fall(ctl_fall),
    .txc_rise(txc_rise), .txc_fall(txc_fall)
);

// File: tb/sim_rgmii_tx_ddr_enc.sv
module sim_rgmii_tx_ddr_enc;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] tx_data;
    logic       tx_en, tx_er;
    logic [1:0] speed_sel;
    logic       byte_take;
    logic [3:0] txd_rise, txd_fall;
    logic       ctl_rise, ctl_fall, txc_rise, txc_fall;

    always #4 clk = ~clk;

    rgmii_tx_ddr_enc u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_en(tx_en),
        .tx_er(tx_er), .speed_sel(speed_sel), .byte_take(byte_take),
        .txd_rise(txd_rise), .txd_fall(txd_fall), .ctl_rise(ctl_rise),
        .ctl_fall(ctl_fall), .txc_rise(txc_rise), .txc_fall(txc_fall)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] st_d   [0:255];
    logic       st_en  [0:255];
    logic       st_er  [0:255];
    logic [1:0] st_sel [0:255];
    int         st_len = 0;

    int         cap_t  [0:1023];
    logic [7:0] cap_d  [0:1023];
    logic       cap_en [0:1023];
    logic       cap_er [0:1023];
    int         cap_n  [0:1023];
    int         n_cap  = 0;

    task automatic add(input logic [7:0] d, input logic en, input logic er,
                       input logic [1:0] sel);
        st_d[st_len] = d; st_en[st_len] = en; st_er[st_len] = er;
        st_sel[st_len] = sel; st_len++;
    endtask

    function automatic int div_for(input logic [1:0] s);
        if (s[1]) return 1;
        if (s[0]) return 5;
        return 50;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input int i);
        tx_data = st_d[i]; tx_en = st_en[i]; tx_er = st_er[i]; speed_sel = st_sel[i];
    endtask

    initial begin
        int  idx, ptr, j, tail;
        bit  adv;
        logic [1:0] eff;

        // gigabit idle, frame with a mid-frame speed request (R7)
        for (int i = 0; i < 3; i++) add(8'h00, 1'b0, 1'b0, 2'b10);
        for (int i = 0; i < 20; i++)
            add(8'(i * 37 + 11), 1'b1, (i == 7), (i == 10) ? 2'b00 : 2'b10);
        for (int i = 0; i < 2; i++) add(8'h0F, 1'b0, 1'b1, 2'b10);
        // 100 Mbit/s frame, error and speed request ignored (R6, R7)
        for (int i = 0; i < 2; i++) add(8'h00, 1'b0, 1'b0, 2'b01);
        for (int i = 0; i < 10; i++)
            add(8'(i * 53 + 3), 1'b1, (i == 4), (i == 5) ? 2'b00 : 2'b01);
        // 10 Mbit/s frame
        for (int i = 0; i < 2; i++) add(8'h00, 1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 4; i++) add(8'hA5 ^ 8'(i * 17), 1'b1, 1'b0, 2'b00);
        add(8'h00, 1'b0, 1'b0, 2'b00);
        // alternate gigabit code
        for (int i = 0; i < 2; i++) add(8'h00, 1'b0, 1'b0, 2'b11);
        for (int i = 0; i < 6; i++) add(8'(i * 29 + 1), 1'b1, 1'b0, 2'b11);
        for (int i = 0; i < 3; i++) add(8'h00, 1'b0, 1'b0, 2'b11);

        rst_n = 1'b0;
        drive(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset txd", {txd_rise, txd_fall}, 0);
        chk("R1 reset ctl/txc", {ctl_rise, ctl_fall, txc_rise, txc_fall}, 0);
        chk("R1 reset ctl/txc again", {ctl_rise, ctl_fall, txc_rise, txc_fall}, 0);
        rst_n = 1'b1;

        idx = 0; ptr = 0; adv = 1'b0; eff = 2'b00; tail = 0; j = 0;
        while (tail < 150) begin
            @(negedge clk);
            j++;
            if (j > 150000) begin
                n_vec++; n_bad++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", j);
                break;
            end
            if (j == 1) chk("R1 take after reset", byte_take, 1);
            if (adv && idx < st_len - 1) begin
                idx++;
                drive(idx);
            end
            if (idx == st_len - 1) tail++;

            // pin model
            while (ptr + 1 < n_cap && cap_t[ptr + 1] + 2 <= j) ptr++;
            if (n_cap > 0 && cap_t[0] + 2 <= j) begin
                int k, nn, c, nib;
                logic [3:0] lo, hi, ed;
                k  = j - (cap_t[ptr] + 2);
                nn = cap_n[ptr];
                lo = cap_d[ptr][3:0]; hi = cap_d[ptr][7:4];
                if (nn == 1) begin
                    chk("R2 R8 gig low nibble", txd_rise, lo);
                    chk("R2 R8 gig high nibble", txd_fall, hi);
                    chk("R2 gig txc", {txc_rise, txc_fall}, 2'b10);
                    chk("R3 gig ctl", {ctl_rise, ctl_fall},
                        {cap_en[ptr], cap_en[ptr] ^ cap_er[ptr]});
                end else if (k < 2 * nn) begin
                    nib = k / nn; c = k % nn;
                    ed  = (nib != 0) ? hi : lo;
                    chk("R5 R8 nibble", {txd_rise, txd_fall}, {ed, ed});
                    chk("R4 txc", {txc_rise, txc_fall},
                        {(2 * c < nn), (2 * c + 1 < nn)});
                    chk("R6 ctl", {ctl_rise, ctl_fall}, {cap_en[ptr], cap_en[ptr]});
                end
            end

            if (byte_take && n_cap < 1024) begin
                if (!tx_en) eff = speed_sel;
                cap_t[n_cap] = j; cap_d[n_cap] = tx_data; cap_en[n_cap] = tx_en;
                cap_er[n_cap] = tx_er; cap_n[n_cap] = div_for(eff);
                if (n_cap > 0)
                    chk("R5 R7 take spacing", j - cap_t[n_cap - 1],
                        (cap_n[n_cap - 1] == 1) ? 1 : 2 * cap_n[n_cap - 1]);
                n_cap++;
            end
            adv = byte_take;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule